// File: doc/BRIEF.md
# Address-Window SPI Byte Bridge

This block lets a host drive an SPI flash using nothing but single-byte loads and stores into a 4 KB memory window. Which page of the window is touched decides what happens on the SPI pins. One page releases the chip select. Another page selects the device and moves exactly one byte: a store sends the stored byte out, and a load clocks a byte in and returns it. A flash command is therefore a store to the release page, a run of stores carrying the opcode, address and payload bytes, and then as many loads as the response needs.

The window can be reached in two ways. The first is a direct 32-bit address port. The second is a narrow indirect port with eight byte offsets. Four of those offsets hold the bytes of a 32-bit pointer, and one offset forwards a load or store to the address that the pointer holds. With the indirect port, software can keep the low and high pointer bytes fixed and rewrite only the page byte. A built-in SPI master runs in mode 0, MSB first, and takes its SCLK from a programmable divider. The host access is held, with a busy indication, until all eight bits have moved.

Top module: `winspi_bridge`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, busy is 0, both acknowledge outputs are 0 and all four indirect pointer bytes read back as 0x00.
- R2: An address hits the window when bits [31:12] equal those of WIN_BASE (default 0xFFFFF000). An access outside the window, or inside it with a page byte (address bits [15:8]) other than PAGE_CS_LO or PAGE_CS_HI, leaves all SPI pins unchanged, returns 0xFF on a load and is acknowledged one cycle after it is first sampled.
- R3: Any access to page PAGE_CS_HI (default 0xFE) drives spi_cs_n to 1 in the cycle after it is sampled and moves no SPI bit. A store's data is ignored, a load returns 0xFF, and the acknowledgement comes after one cycle.
- R4: A store to any address in page PAGE_CS_LO (default 0xFD) drives spi_cs_n to 0 and sends the stored byte MSB first in SPI mode 0. spi_mosi changes only while spi_sclk is low, and the device samples it on each rising edge.
- R5: A load from any address in page PAGE_CS_LO holds spi_cs_n at 0, sends 0xFF on spi_mosi, captures eight spi_miso bits MSB first on the rising SCLK edges, and returns the captured byte as read data.
- R6: Each access to page PAGE_CS_LO makes exactly eight SCLK pulses. Each high phase lasts sck_div+1 clock cycles. The acknowledgement appears 16*(sck_div+1)+2 clock edges after the request is first sampled. busy is high in every cycle before that and falls in the cycle in which the acknowledgement appears.
- R7: spi_sclk is 0 whenever spi_cs_n is 1. spi_cs_n changes only through accesses to the two chip-select pages.
- R8: On the indirect port, offsets 0 to 3 hold pointer bytes P0 to P3, with P0 as address bits [7:0] and P3 as bits [31:24]. A store writes the byte, a load returns it, and both are acknowledged after one cycle.
- R9: A load or store at indirect offset 4 acts on address {P3,P2,P1,P0} with the same effects as the direct port (R2 to R6). Its result appears on io_rdata and io_ack.
- R10: Indirect offsets 5 to 7 ignore stores and return 0xFF on loads. The pointer bytes are not affected.
- R11: Each acknowledgement is a single-cycle pulse. It appears only on the port that made the request, and io_rdata or mem_rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Direct port request, held until mem_ack |
| mem_we | input | 1 | Direct port store (1) or load (0) |
| mem_addr | input | 32 | Direct port byte address |
| mem_wdata | input | 8 | Direct port store data |
| mem_rdata | output | 8 | Direct port load data, valid with mem_ack |
| mem_ack | output | 1 | Direct port completion pulse |
| io_req | input | 1 | Indirect port request, held until io_ack |
| io_we | input | 1 | Indirect port store (1) or load (0) |
| io_addr | input | 3 | Indirect port offset |
| io_wdata | input | 8 | Indirect port store data |
| io_rdata | output | 8 | Indirect port load data, valid with io_ack |
| io_ack | output | 1 | Indirect port completion pulse |
| sck_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| busy | output | 1 | An SPI byte is in flight |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |

## Verification
The bench builds the block with its default parameters: the window at 0xFFFFF000, pages 0xFE and 0xFD, and a 4-bit divider. It drives sck_div at 0, 3 and 15. The value 0 gives the shortest transfer, with one-cycle half periods. The value 15 takes the half-period counter up to its full range. A behavioural SPI device model returns a different byte for each transfer index, so a wrong bit order or a missed sample shows up as a wrong load value. Pointer bytes are set to values other than the page byte, to show that the whole page decodes the same way.

// File: rtl/winspi_pkg.sv
package winspi_pkg;

  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 32;
  localparam int WIN_AW       = 12;
  localparam int IND_REGS     = 4;
  localparam int IO_OFF_W     = 3;
  localparam int IND_DATA_OFF = 4;
  localparam int PAGE_LSB     = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_REG,
    OP_CS_HI,
    OP_SPI_WR,
    OP_SPI_RD
  } op_e;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } acc_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base);
    return addr[ADDR_W-1:WIN_AW] == base[ADDR_W-1:WIN_AW];
  endfunction

  function automatic logic [BYTE_W-1:0] page_of(input logic [ADDR_W-1:0] addr);
    return addr[PAGE_LSB +: BYTE_W];
  endfunction

  function automatic op_e classify(input acc_t a,
                                   input logic [ADDR_W-1:0] base,
                                   input logic [BYTE_W-1:0] pg_hi,
                                   input logic [BYTE_W-1:0] pg_lo);
    if (!in_window(a.addr, base))  return OP_NONE;
    if (page_of(a.addr) == pg_hi)  return OP_CS_HI;
    if (page_of(a.addr) == pg_lo)  return a.we ? OP_SPI_WR : OP_SPI_RD;
    return OP_NONE;
  endfunction

  function automatic logic is_spi(input op_e op);
    return (op == OP_SPI_WR) || (op == OP_SPI_RD);
  endfunction

  function automatic logic [BYTE_W-1:0] tx_value(input acc_t a, input op_e op);
    return (op == OP_SPI_WR) ? a.wdata : {BYTE_W{1'b1}};
  endfunction

endpackage

// File: rtl/winspi_ioregs.sv
module winspi_ioregs
  import winspi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [IO_OFF_W-1:0] off,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   ptr,
  output logic [BYTE_W-1:0]   rd
);

  logic [BYTE_W-1:0] ptr_b [IND_REGS];

  for (genvar g = 0; g < IND_REGS; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_b[g] <= '0;
      else if (wr && off == IO_OFF_W'(g))
        ptr_b[g] <= wdata;
    end
    assign ptr[g*BYTE_W +: BYTE_W] = ptr_b[g];
  end

  always_comb begin
    rd = {BYTE_W{1'b1}};
    for (int i = 0; i < IND_REGS; i++)
      if (off == IO_OFF_W'(i)) rd = ptr_b[i];
  end

endmodule

// File: rtl/winspi_front.sv
module winspi_front
  import winspi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hFFFF_F000,
  parameter logic [BYTE_W-1:0] PAGE_CS_HI = 8'hFE,
  parameter logic [BYTE_W-1:0] PAGE_CS_LO = 8'hFD
) (
  input  logic                mem_req,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [BYTE_W-1:0]   mem_wdata,
  input  logic                io_req,
  input  logic                io_we,
  input  logic [IO_OFF_W-1:0] io_off,
  input  logic [BYTE_W-1:0]   io_wdata,
  input  logic [ADDR_W-1:0]   ptr,
  output logic                req_any,
  output logic                sel_io,
  output acc_t                acc,
  output op_e                 op
);

  always_comb begin
    req_any = mem_req || io_req;
    sel_io  = !mem_req && io_req;
    if (!sel_io) begin
      acc = '{we: mem_we, addr: mem_addr, wdata: mem_wdata};
      op  = classify(acc, WIN_BASE, PAGE_CS_HI, PAGE_CS_LO);
    end else begin
      acc = '{we: io_we, addr: ptr, wdata: io_wdata};
      if (io_off == IO_OFF_W'(IND_DATA_OFF))
        op = classify(acc, WIN_BASE, PAGE_CS_HI, PAGE_CS_LO);
      else if (io_off < IO_OFF_W'(IND_REGS))
        op = OP_REG;
      else
        op = OP_NONE;
    end
  end

endmodule

// File: rtl/winspi_shift.sv
module winspi_shift
  import winspi_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rise_ev,
  output logic              fall_ev
);

  localparam int NEDGE  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(NEDGE);

  logic [DIV_W-1:0]  hcnt;
  logic [EDGE_W-1:0] ecnt;
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_sr;
  logic              tick;
  logic              last_ev;

  assign tick    = active && (hcnt == div);
  assign rise_ev = tick && !sclk;
  assign fall_ev = tick && sclk;
  assign last_ev = fall_ev && (ecnt == EDGE_W'(NEDGE - 1));
  assign mosi    = tx_sr[BYTE_W-1];
  assign rx_byte = rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      sclk   <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done <= last_ev;
      if (start) begin
        active <= 1'b1;
        sclk   <= 1'b0;
        hcnt   <= '0;
        ecnt   <= '0;
        tx_sr  <= tx_byte;
      end else if (active) begin
        if (tick) begin
          hcnt <= '0;
          ecnt <= ecnt + 1'b1;
          sclk <= !sclk;
          if (rise_ev) rx_sr <= {rx_sr[BYTE_W-2:0], miso};
          if (fall_ev) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          if (last_ev) active <= 1'b0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/winspi_bridge.sv
module winspi_bridge
  import winspi_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'hFFFF_F000,
  parameter logic [7:0]  PAGE_CS_HI = 8'hFE,
  parameter logic [7:0]  PAGE_CS_LO = 8'hFD,
  parameter int          DIV_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_req,
  input  logic             mem_we,
  input  logic [31:0]      mem_addr,
  input  logic [7:0]       mem_wdata,
  output logic [7:0]       mem_rdata,
  output logic             mem_ack,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [2:0]       io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_ack,
  input  logic [DIV_W-1:0] sck_div,
  output logic             busy,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  typedef enum logic {ST_IDLE, ST_XFER} state_e;

  state_e            state;
  logic              src_io_q;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] reg_rd;
  logic              req_any;
  logic              sel_io;
  acc_t              acc;
  op_e               op;
  logic              accept;
  logic              sh_start;
  logic              reg_wr;
  logic              sh_active;
  logic              sh_done;
  logic              sh_rise;
  logic              sh_fall;
  logic [BYTE_W-1:0] sh_rx;
  logic              fin;
  logic              fin_io;
  logic [BYTE_W-1:0] fin_data;

  winspi_front #(
    .WIN_BASE  (WIN_BASE),
    .PAGE_CS_HI(PAGE_CS_HI),
    .PAGE_CS_LO(PAGE_CS_LO)
  ) u_front (
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .io_req   (io_req),
    .io_we    (io_we),
    .io_off   (io_addr),
    .io_wdata (io_wdata),
    .ptr      (ptr),
    .req_any  (req_any),
    .sel_io   (sel_io),
    .acc      (acc),
    .op       (op)
  );

  assign accept   = (state == ST_IDLE) && req_any;
  assign sh_start = accept && is_spi(op);
  assign reg_wr   = accept && sel_io && (op == OP_REG) && io_we;

  winspi_ioregs u_ioregs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (reg_wr),
    .off  (io_addr),
    .wdata(io_wdata),
    .ptr  (ptr),
    .rd   (reg_rd)
  );

  winspi_shift #(.DIV_W(DIV_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .tx_byte(tx_value(acc, op)),
    .div    (sck_div),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .active (sh_active),
    .done   (sh_done),
    .rx_byte(sh_rx),
    .rise_ev(sh_rise),
    .fall_ev(sh_fall)
  );

  always_comb begin
    fin      = 1'b0;
    fin_io   = sel_io;
    fin_data = {BYTE_W{1'b1}};
    if (accept && !is_spi(op)) begin
      fin = 1'b1;
      if (op == OP_REG) fin_data = reg_rd;
    end else if (state == ST_XFER && sh_done) begin
      fin      = 1'b1;
      fin_io   = src_io_q;
      fin_data = sh_rx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      src_io_q  <= 1'b0;
      spi_cs_n  <= 1'b1;
      mem_ack   <= 1'b0;
      io_ack    <= 1'b0;
      mem_rdata <= '0;
      io_rdata  <= '0;
    end else begin
      mem_ack <= fin && !fin_io;
      io_ack  <= fin && fin_io;
      if (fin && !fin_io) mem_rdata <= fin_data;
      if (fin && fin_io)  io_rdata  <= fin_data;
      if (accept) begin
        if (op == OP_CS_HI) spi_cs_n <= 1'b1;
        if (is_spi(op)) begin
          spi_cs_n <= 1'b0;
          state    <= ST_XFER;
          src_io_q <= sel_io;
        end
      end else if (state == ST_XFER && sh_done) begin
        state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_XFER);

endmodule

// File: rtl/winspi_checker.sv
module winspi_checker (
  input logic clk,
  input logic rst_n,
  input logic mem_ack,
  input logic io_ack,
  input logic busy,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic sh_active,
  input logic sh_done
);

  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R7

  AST_SELECTED_WHILE_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !spi_cs_n); // R4

  AST_MOSI_HELD_IN_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_sclk) && spi_sclk) |-> $stable(spi_mosi)); // R4

  AST_DONE_GIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> (mem_ack || io_ack)); // R6

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mem_ack || io_ack)); // R6

  AST_SCLK_RISE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> busy); // R6

endmodule

bind winspi_bridge winspi_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_ack  (mem_ack),
  .io_ack   (io_ack),
  .busy     (busy),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi),
  .sh_active(sh_active),
  .sh_done  (sh_done)
);

// File: tb/winspi_bridge_test.sv
`timescale 1ns/1ps
module winspi_bridge_test;

  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mem_req = 0, mem_we = 0;
  logic [31:0]      mem_addr = '0;
  logic [7:0]       mem_wdata = '0;
  logic [7:0]       mem_rdata;
  logic             mem_ack;
  logic             io_req = 0, io_we = 0;
  logic [2:0]       io_addr = '0;
  logic [7:0]       io_wdata = '0;
  logic [7:0]       io_rdata;
  logic             io_ack;
  logic [DIV_W-1:0] sck_div = '0;
  logic             busy, spi_sclk, spi_cs_n, spi_mosi;
  logic             spi_miso = 1'b0;

  always #2 clk = ~clk;

  winspi_bridge #(.DIV_W(DIV_W)) uut (.*);

  int tests = 0, fails = 0;
  logic exp_cs = 1'b1;
  int spi_count = 0;
  logic [7:0] ptr_m [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model: response byte depends only on the transfer index
  function automatic logic [7:0] resp(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  logic [7:0] mosi_q[$];
  int nb = 0, nbytes = 0;
  logic [7:0] shin = '0;
  always @(posedge spi_sclk) begin
    shin = {shin[6:0], spi_mosi};
    nb++;
    if (nb == 8) begin
      mosi_q.push_back(shin);
      nb = 0;
      nbytes++;
    end
  end
  always @(negedge spi_sclk or negedge spi_cs_n) begin
    logic [7:0] r;
    r = resp(nbytes);
    spi_miso = r[7 - nb];
  end

  // per-clock reference comparison and watchdog
  logic prev_sclk = 0, prev_mosi = 0;
  int hi_run = 0, cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n) begin
      if (spi_cs_n !== exp_cs) chk("R7 chip select tracks page accesses", spi_cs_n, exp_cs);
      if (spi_cs_n && spi_sclk) chk("R7 sclk low while deselected", spi_sclk, 0);
      if (prev_sclk && spi_sclk && spi_mosi !== prev_mosi) chk("R4 mosi stable while sclk high", spi_mosi, prev_mosi);
      if (prev_sclk && !spi_sclk) chk("R6 sclk high phase length", hi_run, int'(sck_div) + 1);
      hi_run = spi_sclk ? hi_run + 1 : 0;
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
    end
  end

  // 0 none, 1 release, 2 spi byte
  function automatic int kind(input logic [31:0] a);
    if (a[31:12] != 20'hFFFFF) return 0;
    if (a[15:8] == 8'hFE) return 1;
    if (a[15:8] == 8'hFD) return 2;
    return 0;
  endfunction

  task automatic do_acc(input bit use_io, input bit we, input logic [31:0] addr,
                        input logic [31:0] maddr, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat,
                        output bit busy_ok, output bit ack_ok);
    bit a;
    @(negedge clk);
    if (use_io) begin io_req = 1; io_we = we; io_addr = addr[2:0]; io_wdata = wd; end
    else begin mem_req = 1; mem_we = we; mem_addr = addr; mem_wdata = wd; end
    if (kind(maddr) == 1) exp_cs = 1'b1;
    if (kind(maddr) == 2) exp_cs = 1'b0;
    lat = 0; busy_ok = 1; ack_ok = 1;
    do begin
      @(negedge clk);
      lat++;
      a = use_io ? io_ack : mem_ack;
      if (use_io ? mem_ack : io_ack) ack_ok = 0;
      if (!a && !busy) busy_ok = 0;
      if (a && busy) busy_ok = 0;
    end while (!a && lat < 5000);
    rd = use_io ? io_rdata : mem_rdata;
    io_req = 0; mem_req = 0;
    @(negedge clk);
    if (io_ack || mem_ack) ack_ok = 0;
  endtask

  task automatic spi_acc(input string tag, input bit use_io, input bit we,
                         input logic [31:0] addr, input logic [7:0] wd);
    logic [7:0] rd; int lat; bit bok, aok; logic [7:0] m; int k;
    logic [31:0] ma;
    ma = use_io ? {ptr_m[3], ptr_m[2], ptr_m[1], ptr_m[0]} : addr;
    k = spi_count;
    do_acc(use_io, we, addr, ma, wd, rd, lat, bok, aok);
    spi_count++;
    chk({tag, " R6 latency"}, lat, 16 * (int'(sck_div) + 1) + 2);
    chk({tag, " R6 busy window"}, bok, 1);
    chk({tag, " R11 ack pulse"}, aok, 1);
    m = (mosi_q.size() > 0) ? mosi_q.pop_front() : 8'hXX;
    if (we) chk({tag, " R4 mosi byte"}, m, wd);
    else begin
      chk({tag, " R5 mosi idle byte"}, m, 8'hFF);
      chk({tag, " R5 read data"}, rd, resp(k));
    end
  endtask

  task automatic plain_acc(input string tag, input bit use_io, input bit we,
                           input logic [31:0] addr, input logic [7:0] wd,
                           input logic [7:0] exp_rd);
    logic [7:0] rd; int lat; bit bok, aok;
    logic [31:0] ma;
    ma = (use_io && addr[2:0] == 3'd4) ? {ptr_m[3], ptr_m[2], ptr_m[1], ptr_m[0]}
       : (use_io ? 32'h0 : addr);
    do_acc(use_io, we, addr, ma, wd, rd, lat, bok, aok);
    if (use_io && we && addr[2:0] < 3'd4) ptr_m[addr[1:0]] = wd;
    chk({tag, " latency"}, lat, 1);
    chk({tag, " R11 ack pulse"}, aok, 1);
    chk({tag, " no spi byte"}, mosi_q.size(), 0);
    if (!we) chk({tag, " read data"}, rd, exp_rd);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs after reset", spi_cs_n, 1);
    chk("R1 sclk after reset", spi_sclk, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 acks after reset", {mem_ack, io_ack}, 0);
    for (int i = 0; i < 4; i++) plain_acc("R1 R8 pointer reset", 1, 0, 32'(i), 8'h00, 8'h00);

    sck_div = 0;
    plain_acc("R3 release store", 0, 1, 32'hFFFF_FE40, 8'h5A, 8'hFF);
    spi_acc("R4 opcode store", 0, 1, 32'hFFFF_FD00, 8'h9F);
    for (int i = 0; i < 3; i++) spi_acc("R5 response load", 0, 0, 32'hFFFF_FD7C, 8'h00);
    plain_acc("R3 release load", 0, 0, 32'hFFFF_FE00, 8'h00, 8'hFF);
    spi_acc("R4 store after release", 0, 1, 32'hFFFF_FDFF, 8'h01);
    plain_acc("R2 outside window store", 0, 1, 32'h0000_FD00, 8'hAA, 8'hFF);
    plain_acc("R2 outside window load", 0, 0, 32'h1234_FD10, 8'h00, 8'hFF);
    plain_acc("R2 other page load", 0, 0, 32'hFFFF_F012, 8'h00, 8'hFF);
    plain_acc("R2 other page store", 0, 1, 32'hFFFF_FC00, 8'h33, 8'hFF);

    sck_div = 3;
    plain_acc("R8 ptr0 store", 1, 1, 0, 8'h33, 8'h00);
    plain_acc("R8 ptr1 store", 1, 1, 1, 8'hFD, 8'h00);
    plain_acc("R8 ptr2 store", 1, 1, 2, 8'hFF, 8'h00);
    plain_acc("R8 ptr3 store", 1, 1, 3, 8'hFF, 8'h00);
    plain_acc("R8 ptr1 load", 1, 0, 1, 8'h00, 8'hFD);
    plain_acc("R8 ptr0 load", 1, 0, 0, 8'h00, 8'h33);
    spi_acc("R9 indirect store", 1, 1, 4, 8'hC6);
    spi_acc("R9 indirect load", 1, 0, 4, 8'h00);
    plain_acc("R8 ptr1 to release", 1, 1, 1, 8'hFE, 8'h00);
    plain_acc("R9 R3 indirect release", 1, 1, 4, 8'h12, 8'hFF);
    plain_acc("R8 ptr1 to select", 1, 1, 1, 8'hFD, 8'h00);
    spi_acc("R9 indirect reselect store", 1, 1, 4, 8'h0B);

    plain_acc("R10 offset 6 store", 1, 1, 6, 8'h77, 8'h00);
    plain_acc("R10 offset 6 load", 1, 0, 6, 8'h00, 8'hFF);
    plain_acc("R10 offset 5 load", 1, 0, 5, 8'h00, 8'hFF);
    plain_acc("R10 offset 7 store", 1, 1, 7, 8'h01, 8'h00);
    for (int i = 0; i < 4; i++) plain_acc("R10 pointer intact", 1, 0, 32'(i), 8'h00, ptr_m[i]);

    sck_div = 15;
    spi_acc("R6 slowest divider load", 0, 0, 32'hFFFF_FD00, 8'h00);
    sck_div = 0;
    plain_acc("R3 final release", 0, 1, 32'hFFFF_FE00, 8'h00, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R7 idle sclk at end", spi_sclk, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule